// File: doc/BRIEF.md
# Board Control Register File

This block is a bank of word-wide registers in a 4 KB window that holds control and identification state for a board. The host reaches it through a simple synchronous port. Each access is a full 32-bit word and names a word index. Read data comes back one cycle after the request. Two registers drive board-level wires: one sets a remap line from its least significant bit, and one sets a row of LED lines, one bit per LED.

The identity value is a build parameter, and the block decodes it to find out which variant it is. A 12-bit part number sits in ID bits [15:4]. Three optional registers exist only for some part numbers. On other builds their offsets behave exactly like empty space. A lock-status word brings together three things: a writable mask byte, the live lock state of eight clock loops, and a summary bit. The summary bit says that every loop selected by the mask is locked. The configuration transaction channel at byte offsets 0xA0 to 0xAC belongs to a separate block, so here those offsets are empty space.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset the following values hold. The control word (byte 0x00) equals parameter CTRL0_RST and `remap` equals its bit 0. The LED word, select word, rate word and divider word all read zero, and `leds` is zero. The lock word reads 0xFFFF_0001 while `loop_lock` is 0xFF.
- R2: A read request (`req_valid`=1, `req_write`=0) places its data on `rsp_rdata` at the next rising edge. `rsp_rdata` holds that value until the next read request.
- R3: The control word at byte 0x00 stores all 32 written bits, and `remap` follows its bit 0 from the edge after the write.
- R4: The LED word at byte 0x04 stores all 32 written bits, and `leds[i]` follows its bit i from the edge after the write.
- R5: The select word (byte 0x08) and the rate word (byte 0x14) are read/write only when the part number (ID bits [15:4]) is 0x524 or 0x547. For any other part number they read zero and drop writes.
- R6: The divider word (byte 0x18) is read/write only for part number 0x524. For any other part number it reads zero and drops writes.
- R7: Byte 0x0C always reads zero, and writes to it have no effect.
- R8: Byte 0x10 reads parameter INFO_VAL, byte 0xFF8 reads AUX_ID_VAL and byte 0xFFC reads ID_VAL. Writes to these offsets change nothing.
- R9: Any other offset, including 0xA0 to 0xAC and 0x200, reads zero and drops writes.
- R10: The lock word (byte 0x100) has the following fields. Bits [31:24] are a writable mask. Bits [23:16] show `loop_lock` as sampled at the read request. Bit 0 is 1 exactly when every `loop_lock` bit whose mask bit is 1 is also 1. All other bits read zero, and writes touch only the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_widx | input | 10 | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| loop_lock | input | 8 | Live lock state of the clock loops |
| remap | output | 1 | Remap line, control word bit 0 |
| leds | output | NUM_LEDS | LED lines from the LED word |

## Verification
Three instances share one stimulus stream, and each carries a different part number: 0x524, 0x547 and 0x511. The same access to an optional offset must therefore read back on some instances and read zero on the others. This separates the select/rate gating from the divider gating. The lock word is exercised with several pairs of mask and loop state. Some pairs leave the summary bit set and others clear it, so an inverted mask or a plain AND of the loops gives a wrong result. Writes to read-only, zero and empty offsets are each followed by a read-back, so a write that leaks into storage shows up at the port.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int NSLOT  = 10;
    localparam int WIDX_W = 10;

    localparam int SL_CTRL  = 0;
    localparam int SL_LED   = 1;
    localparam int SL_SEL   = 2;
    localparam int SL_ZERO  = 3;
    localparam int SL_INFO  = 4;
    localparam int SL_RATE  = 5;
    localparam int SL_DIV   = 6;
    localparam int SL_LOCK  = 7;
    localparam int SL_AUX   = 8;
    localparam int SL_IDENT = 9;

    localparam logic [11:0] PART_FULL = 12'h524;
    localparam logic [11:0] PART_MID  = 12'h547;

    // word index of each slot within the 4 KB window
    function automatic logic [WIDX_W-1:0] slot_widx(input int s);
        case (s)
            SL_CTRL:  return 10'h000;
            SL_LED:   return 10'h001;
            SL_SEL:   return 10'h002;
            SL_ZERO:  return 10'h003;
            SL_INFO:  return 10'h004;
            SL_RATE:  return 10'h005;
            SL_DIV:   return 10'h006;
            SL_LOCK:  return 10'h040;
            SL_AUX:   return 10'h3FE;
            default:  return 10'h3FF;
        endcase
    endfunction

    // whether a slot exists for a given part number
    function automatic logic slot_present(input int s, input logic [11:0] part);
        case (s)
            SL_SEL, SL_RATE: return (part == PART_FULL) || (part == PART_MID);
            SL_DIV:          return (part == PART_FULL);
            default:         return 1'b1;
        endcase
    endfunction

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] led;
        logic [31:0] sel;
        logic [31:0] rate;
        logic [31:0] div;
        logic [7:0]  mask;
    } bcr_state_t;

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter logic [11:0] PART = 12'h524
) (
    input  logic [WIDX_W-1:0] widx,
    output logic [NSLOT-1:0]  hit
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic PRESENT = slot_present(s, PART);
        if (PRESENT) begin : g_on
            assign hit[s] = (widx == slot_widx(s));
        end else begin : g_off
            assign hit[s] = 1'b0;
        end
    end
endmodule

// File: rtl/bcr_regs.sv
module bcr_regs
    import bcr_pkg::*;
#(
    parameter logic [31:0] CTRL0_RST = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NSLOT-1:0] hit,
    input  logic [31:0]      wdata,
    output bcr_state_t       state
);
    bcr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (hit[SL_CTRL]) st_d.ctrl = wdata;
            if (hit[SL_LED])  st_d.led  = wdata;
            if (hit[SL_SEL])  st_d.sel  = wdata;
            if (hit[SL_RATE]) st_d.rate = wdata;
            if (hit[SL_DIV])  st_d.div  = wdata;
            if (hit[SL_LOCK]) st_d.mask = wdata[31:24];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL0_RST;
            st_q.led  <= '0;
            st_q.sel  <= '0;
            st_q.rate <= '0;
            st_q.div  <= '0;
            st_q.mask <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
    import bcr_pkg::*;
#(
    parameter logic [31:0] INFO_VAL   = 32'h0,
    parameter logic [31:0] AUX_ID_VAL = 32'h0,
    parameter logic [31:0] ID_VAL     = 32'h0
) (
    input  logic [NSLOT-1:0] hit,
    input  bcr_state_t       state,
    input  logic [7:0]       loop_lock,
    output logic [31:0]      rdata
);
    logic        all_locked;
    logic [31:0] lock_word;
    logic [31:0] slot_val [NSLOT];

    assign all_locked = &(loop_lock | ~state.mask);
    assign lock_word  = {state.mask, loop_lock, 15'h0, all_locked};

    always_comb begin
        slot_val[SL_CTRL]  = state.ctrl;
        slot_val[SL_LED]   = state.led;
        slot_val[SL_SEL]   = state.sel;
        slot_val[SL_ZERO]  = 32'h0;
        slot_val[SL_INFO]  = INFO_VAL;
        slot_val[SL_RATE]  = state.rate;
        slot_val[SL_DIV]   = state.div;
        slot_val[SL_LOCK]  = lock_word;
        slot_val[SL_AUX]   = AUX_ID_VAL;
        slot_val[SL_IDENT] = ID_VAL;
    end

    // hit is one-hot or empty, so an AND-OR tree suffices
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NSLOT; s++) begin
            rdata = rdata | (slot_val[s] & {32{hit[s]}});
        end
    end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int          NUM_LEDS   = 8,
    parameter logic [31:0] CTRL0_RST  = 32'h0000_0001,
    parameter logic [31:0] INFO_VAL   = 32'h0000_0042,
    parameter logic [31:0] AUX_ID_VAL = 32'h0505_0001,
    parameter logic [31:0] ID_VAL     = 32'h4105_5240
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [9:0]          req_widx,
    input  logic [31:0]         req_wdata,
    output logic [31:0]         rsp_rdata,
    input  logic [7:0]          loop_lock,
    output logic                remap,
    output logic [NUM_LEDS-1:0] leds
);
    localparam logic [11:0] PART = ID_VAL[15:4];

    logic [NSLOT-1:0] hit;
    bcr_state_t       state;
    logic [31:0]      mux_data;
    logic             wr_en, rd_en;
    logic [31:0]      rdata_d, rdata_q;

    assign wr_en = req_valid &  req_write;
    assign rd_en = req_valid & ~req_write;

    bcr_decode #(.PART(PART)) u_dec (
        .widx (req_widx),
        .hit  (hit)
    );

    bcr_regs #(.CTRL0_RST(CTRL0_RST)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .hit   (hit),
        .wdata (req_wdata),
        .state (state)
    );

    bcr_rdmux #(
        .INFO_VAL   (INFO_VAL),
        .AUX_ID_VAL (AUX_ID_VAL),
        .ID_VAL     (ID_VAL)
    ) u_mux (
        .hit       (hit),
        .state     (state),
        .loop_lock (loop_lock),
        .rdata     (mux_data)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = mux_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rsp_rdata = rdata_q;
    assign remap     = state.ctrl[0];
    assign leds      = state.led[NUM_LEDS-1:0];
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int          NUM_LEDS = 8,
    parameter logic [31:0] ID_VAL   = 32'h0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [9:0]          req_widx,
    input logic [31:0]         req_wdata,
    input logic [31:0]         rsp_rdata,
    input logic [7:0]          loop_lock,
    input logic                remap,
    input logic [NUM_LEDS-1:0] leds
);
    logic rd, wr;
    assign rd = req_valid & ~req_write;
    assign wr = req_valid &  req_write;

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rsp_rdata));

    // R3
    remap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_widx == 10'h000) |=> (remap == $past(req_wdata[0])));

    // R4
    led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_widx == 10'h001) |=> (leds == $past(req_wdata[NUM_LEDS-1:0])));

    // R7
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_widx == 10'h003) |=> (rsp_rdata == 32'h0));

    // R8
    ident_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_widx == 10'h3FF) |=> (rsp_rdata == ID_VAL));

    // R9
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_widx == 10'h028) |=> (rsp_rdata == 32'h0));

    // R10
    lock_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_widx == 10'h040) |=>
            (rsp_rdata[23:16] == $past(loop_lock) && rsp_rdata[15:1] == 15'h0));
endmodule

bind board_ctrl_regs bcr_checker #(
    .NUM_LEDS (NUM_LEDS),
    .ID_VAL   (ID_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_widx  (req_widx),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .loop_lock (loop_lock),
    .remap     (remap),
    .leds      (leds)
);

// File: tb/sim_board_ctrl_regs.sv
module sim_board_ctrl_regs;
    localparam logic [31:0] INFO = 32'h0000_0042;
    localparam logic [31:0] AUX  = 32'h0505_0001;
    localparam logic [31:0] ID0  = 32'h4105_5240; // part 0x524
    localparam logic [31:0] ID1  = 32'h0100_5470; // part 0x547
    localparam logic [31:0] ID2  = 32'h0100_5110; // part 0x511

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_widx = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  loop_lock = 8'hFF;
    logic [31:0] rd0, rd1, rd2;
    logic        rm0, rm1, rm2;
    logic [7:0]  ld0, ld1, ld2;

    int checks = 0, fails = 0;

    typedef struct {
        int          inst;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    board_ctrl_regs #(.ID_VAL(ID0), .INFO_VAL(INFO), .AUX_ID_VAL(AUX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_widx(req_widx), .req_wdata(req_wdata), .rsp_rdata(rd0),
        .loop_lock(loop_lock), .remap(rm0), .leds(ld0));
    board_ctrl_regs #(.ID_VAL(ID1), .INFO_VAL(INFO), .AUX_ID_VAL(AUX)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_widx(req_widx), .req_wdata(req_wdata), .rsp_rdata(rd1),
        .loop_lock(loop_lock), .remap(rm1), .leds(ld1));
    board_ctrl_regs #(.ID_VAL(ID2), .INFO_VAL(INFO), .AUX_ID_VAL(AUX)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_widx(req_widx), .req_wdata(req_wdata), .rsp_rdata(rd2),
        .loop_lock(loop_lock), .remap(rm2), .leds(ld2));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // monitor: compare queued expectations just after the registering edge
    always @(posedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = (it.inst == 0) ? rd0 : (it.inst == 1) ? rd1 : rd2;
            check($sformatf("%s inst%0d", it.tag, it.inst), act, it.exp);
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic wr(input logic [9:0] w, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_widx = w; req_wdata = d;
        idle();
    endtask

    task automatic rd(input logic [9:0] w, input logic [31:0] e0,
                      input logic [31:0] e1, input logic [31:0] e2, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_widx = w;
        it.tag = tag;
        it.inst = 0; it.exp = e0; sb_q.push_back(it);
        it.inst = 1; it.exp = e1; sb_q.push_back(it);
        it.inst = 2; it.exp = e2; sb_q.push_back(it);
        idle();
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 remap", {31'h0, rm0}, 32'h1);
        check("R1 leds", {24'h0, ld0}, 32'h0);
        rd(10'h000, 32'h1, 32'h1, 32'h1, "R1 ctrl");
        rd(10'h002, 32'h0, 32'h0, 32'h0, "R1 sel");
        rd(10'h040, 32'hFFFF_0001, 32'hFFFF_0001, 32'hFFFF_0001, "R1 lock");

        // R3 control word and remap
        wr(10'h000, 32'hCAFE_0000);
        check("R3 remap low", {31'h0, rm0}, 32'h0);
        wr(10'h000, 32'h1234_5673);
        check("R3 remap high", {31'h0, rm2}, 32'h1);
        rd(10'h000, 32'h1234_5673, 32'h1234_5673, 32'h1234_5673, "R3 ctrl");

        // R4 LEDs
        wr(10'h001, 32'h0F00_00A5);
        check("R4 leds", {24'h0, ld1}, 32'hA5);
        rd(10'h001, 32'h0F00_00A5, 32'h0F00_00A5, 32'h0F00_00A5, "R4 led word");

        // R2 read data holds with no further read
        repeat (3) @(negedge clk);
        check("R2 hold", rd0, 32'h0F00_00A5);

        // R5 select and rate, R6 divider
        wr(10'h002, 32'h0000_0003);
        wr(10'h005, 32'h017D_7840);
        wr(10'h006, 32'h0000_0009);
        rd(10'h002, 32'h3, 32'h3, 32'h0, "R5 sel");
        rd(10'h005, 32'h017D_7840, 32'h017D_7840, 32'h0, "R5 rate");
        rd(10'h006, 32'h9, 32'h0, 32'h0, "R6 div");

        // R7 zero slot
        wr(10'h003, 32'hFFFF_FFFF);
        rd(10'h003, 32'h0, 32'h0, 32'h0, "R7 zero");

        // R8 read-only values
        wr(10'h004, 32'hDEAD_BEEF);
        wr(10'h3FE, 32'hDEAD_BEEF);
        wr(10'h3FF, 32'hDEAD_BEEF);
        rd(10'h004, INFO, INFO, INFO, "R8 info");
        rd(10'h3FE, AUX, AUX, AUX, "R8 aux");
        rd(10'h3FF, ID0, ID1, ID2, "R8 ident");

        // R9 empty offsets
        wr(10'h080, 32'h5555_AAAA);
        wr(10'h028, 32'h5555_AAAA);
        rd(10'h080, 32'h0, 32'h0, 32'h0, "R9 hole 0x200");
        rd(10'h028, 32'h0, 32'h0, 32'h0, "R9 hole 0xA0");
        rd(10'h02B, 32'h0, 32'h0, 32'h0, "R9 hole 0xAC");
        rd(10'h000, 32'h1234_5673, 32'h1234_5673, 32'h1234_5673, "R9 ctrl intact");

        // R10 lock word
        wr(10'h040, 32'h1234_5678);
        rd(10'h040, 32'h12FF_0001, 32'h12FF_0001, 32'h12FF_0001, "R10 mask all locked");
        loop_lock = 8'h0F;
        rd(10'h040, 32'h120F_0000, 32'h120F_0000, 32'h120F_0000, "R10 masked unlocked");
        wr(10'h040, 32'h0F00_0000);
        rd(10'h040, 32'h0F0F_0001, 32'h0F0F_0001, 32'h0F0F_0001, "R10 masked locked");
        loop_lock = 8'h00;
        wr(10'h040, 32'h00FF_FFFF);
        rd(10'h040, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, "R10 empty mask");

        // R1 reset again clears writable state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        loop_lock = 8'hFF;
        check("R1 leds after reset", {24'h0, ld0}, 32'h0);
        check("R1 remap after reset", {31'h0, rm1}, 32'h1);
        rd(10'h005, 32'h0, 32'h0, 32'h0, "R1 rate");
        rd(10'h006, 32'h0, 32'h0, 32'h0, "R1 div");
        rd(10'h040, 32'hFFFF_0001, 32'hFFFF_0001, 32'hFFFF_0001, "R1 lock after reset");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule